// File: doc/BRIEF.md
# Bidirectional gate-line scan shifter

This block steps a single scan token along a row of gate-line outputs of a display panel, one row per rising edge of the shift clock. A direction input chooses which end of the row the token enters at and which way it travels. Each end of the row has a start-pulse port, modelled as an input, an output and an output enable. The port at the entry end samples a new token. The port at the exit end drives out the token that leaves the last stage, so that several of these shifters can be chained across a wide panel.

An output-enable input blanks every gate-line output without touching the token register, so scanning continues unseen while outputs are blanked. When the double-scan input is sampled high on a clock edge, each token also lights the next row in the direction of travel, so two rows are driven at once. A width-trim input, which acts without waiting for the clock, can end the token's own row early while the partner row stays on. The outputs are logic-level only.

Top module: `gate_scan_shifter`

## Requirements
- R1: A synchronous active-low reset clears every stage, clears the double-scan flag and sets the registered direction to forward. While reset is asserted, every scan output reads 0 after the next clock edge.
- R2: While `dir_fwd` is 1 at a clock edge, `pulse_a_in` is sampled into stage 0 (`scan_out[0]`) and every token moves from stage k to stage k+1. A token leaves the chain after stage NUM_STAGES-1.
- R3: While `dir_fwd` is 0 at a clock edge, `pulse_b_in` is sampled into stage NUM_STAGES-1 and every token moves from stage k to stage k-1. A token leaves the chain after stage 0.
- R4: `dir_fwd` is registered on each clock edge. When the registered direction is forward, `pulse_b_oe`=1, `pulse_a_oe`=0, `pulse_b_out` equals stage NUM_STAGES-1 and `pulse_a_out`=0. When it is reverse, the roles of the two ports swap and `pulse_a_out` equals stage 0. The cascade outputs are not masked by `oe`.
- R5: While `oe` is 0, every scan output is 0. Tokens keep shifting, and they reappear at their advanced positions once `oe` returns to 1.
- R6: When `dbl_scan` was 1 at the last clock edge, a token in stage k also drives the neighbour stage in the registered direction (k+1 when forward, k-1 when reverse). No partner is driven beyond either end of the chain.
- R7: In double-scan mode, the token's own row is driven only while `dbl_width` is 1. It drops in the same cycle that `dbl_width` falls, without waiting for a clock edge, and the partner row is unaffected. In normal mode `dbl_width` has no effect.
- R8: Several tokens may be in the chain at the same time. Each one shifts on its own, with no merging or arbitration.
- R9: A change of `dir_fwd` takes effect at the next clock edge. The tokens already in the chain keep their positions and only change the way they move.
- R10: The start-pulse input at the exit end has no effect: `pulse_b_in` is ignored while moving forward and `pulse_a_in` is ignored while moving in reverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_fwd | input | 1 | 1: token travels from stage 0 upward; 0: downward |
| oe | input | 1 | Output enable; 0 forces all scan outputs low |
| dbl_scan | input | 1 | Double-scan request, sampled on each clock edge |
| dbl_width | input | 1 | Asynchronous trim of the token's own row in double-scan mode |
| pulse_a_in | input | 1 | Start-pulse input at the stage-0 end |
| pulse_a_out | output | 1 | Cascade output at the stage-0 end |
| pulse_a_oe | output | 1 | Drive enable for the stage-0 end port |
| pulse_b_in | input | 1 | Start-pulse input at the last-stage end |
| pulse_b_out | output | 1 | Cascade output at the last-stage end |
| pulse_b_oe | output | 1 | Drive enable for the last-stage end port |
| scan_out | output | NUM_STAGES | Gate-line scan outputs, bit k is row k |

## Verification
On every cycle, the assertions check the per-edge shift in both directions, the ownership of the cascade ports, the blanking under a low output enable, the trimming of the token's own row and the reset clearing. Some behaviour only shows across many cycles, and the bench's scenarios cover it: a token re-emerging at the correct row after blanking, two tokens travelling together, and a direction reversal in mid-chain that leaves the tokens intact. The same holds for the asynchronous drop when the trim input falls between clock edges and for a token leaving through the cascade port. The reference model follows token positions as integers and compares every output on each clock.

// File: rtl/gsc_pkg.sv
package gsc_pkg;

  // Direction of travel as held in the mode register.
  typedef enum logic {
    GSC_REV = 1'b0,
    GSC_FWD = 1'b1
  } gsc_dir_e;

  // Select the neighbour that feeds a row's partner output in double scan:
  // the stage behind it in the direction of travel.
  function automatic logic gsc_partner(input logic fwd, input logic below, input logic above);
    return fwd ? below : above;
  endfunction

  // Own-row drive: in double scan the trim input must be high.
  function automatic logic gsc_own_row(input logic tok, input logic dbl, input logic trim_hi);
    return tok & (~dbl | trim_hi);
  endfunction

endpackage

// File: rtl/gsc_shift_chain.sv
module gsc_shift_chain #(
  parameter int N = 240
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dir_fwd,
  input  logic         head_in,
  input  logic         tail_in,
  output logic [N-1:0] stage_q
);

  logic [N-1:0] fwd_next;
  logic [N-1:0] rev_next;

  assign fwd_next = {stage_q[N-2:0], head_in};
  assign rev_next = {tail_in, stage_q[N-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else if (dir_fwd) begin
      stage_q <= fwd_next;
    end else begin
      stage_q <= rev_next;
    end
  end

endmodule

// File: rtl/gsc_scan_mode.sv
module gsc_scan_mode
  import gsc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     dir_fwd,
  input  logic     dbl_scan,
  output gsc_dir_e dir_q,
  output logic     ds_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= GSC_FWD;
      ds_q  <= 1'b0;
    end else begin
      dir_q <= dir_fwd ? GSC_FWD : GSC_REV;
      ds_q  <= dbl_scan;
    end
  end

endmodule

// File: rtl/gsc_out_stage.sv
module gsc_out_stage
  import gsc_pkg::*;
#(
  parameter int N = 240
) (
  input  logic [N-1:0] stage_q,
  input  logic         fwd_q,
  input  logic         ds_q,
  input  logic         dbl_width,
  input  logic         oe,
  output logic [N-1:0] pair_hit,
  output logic [N-1:0] own_hit,
  output logic [N-1:0] scan_out
);

  for (genvar i = 0; i < N; i++) begin : g_row
    logic below;
    logic above;
    if (i == 0) begin : g_lo_end
      assign below = 1'b0;
    end else begin : g_lo_mid
      assign below = stage_q[i-1];
    end
    if (i == N - 1) begin : g_hi_end
      assign above = 1'b0;
    end else begin : g_hi_mid
      assign above = stage_q[i+1];
    end
    assign pair_hit[i] = ds_q & gsc_partner(fwd_q, below, above);
    assign own_hit[i]  = gsc_own_row(stage_q[i], ds_q, dbl_width);
    assign scan_out[i] = oe & (own_hit[i] | pair_hit[i]);
  end

endmodule

// File: rtl/gate_scan_shifter.sv
module gate_scan_shifter
  import gsc_pkg::*;
#(
  parameter int NUM_STAGES = 240
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dir_fwd,
  input  logic                  oe,
  input  logic                  dbl_scan,
  input  logic                  dbl_width,
  input  logic                  pulse_a_in,
  output logic                  pulse_a_out,
  output logic                  pulse_a_oe,
  input  logic                  pulse_b_in,
  output logic                  pulse_b_out,
  output logic                  pulse_b_oe,
  output logic [NUM_STAGES-1:0] scan_out
);

  localparam int LAST = NUM_STAGES - 1;

  logic [NUM_STAGES-1:0] stage_q;
  logic [NUM_STAGES-1:0] pair_hit;
  logic [NUM_STAGES-1:0] own_hit;
  gsc_dir_e              dir_q;
  logic                  fwd_q;
  logic                  ds_q;

  gsc_shift_chain #(.N(NUM_STAGES)) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .dir_fwd (dir_fwd),
    .head_in (pulse_a_in),
    .tail_in (pulse_b_in),
    .stage_q (stage_q)
  );

  gsc_scan_mode u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .dir_fwd  (dir_fwd),
    .dbl_scan (dbl_scan),
    .dir_q    (dir_q),
    .ds_q     (ds_q)
  );

  assign fwd_q = (dir_q == GSC_FWD);

  gsc_out_stage #(.N(NUM_STAGES)) u_out (
    .stage_q   (stage_q),
    .fwd_q     (fwd_q),
    .ds_q      (ds_q),
    .dbl_width (dbl_width),
    .oe        (oe),
    .pair_hit  (pair_hit),
    .own_hit   (own_hit),
    .scan_out  (scan_out)
  );

  // Cascade ports: the exit end drives the token leaving the last stage.
  assign pulse_b_oe  = fwd_q;
  assign pulse_a_oe  = ~fwd_q;
  assign pulse_b_out = fwd_q & stage_q[LAST];
  assign pulse_a_out = ~fwd_q & stage_q[0];

endmodule

// File: rtl/gsc_checker.sv
module gsc_checker #(
  parameter int N = 240
) (
  input logic         clk,
  input logic         rst_n,
  input logic         dir_fwd,
  input logic         oe,
  input logic         dbl_width,
  input logic         pulse_a_in,
  input logic         pulse_b_in,
  input logic         pulse_a_out,
  input logic         pulse_b_out,
  input logic         pulse_a_oe,
  input logic         pulse_b_oe,
  input logic [N-1:0] scan_out,
  input logic [N-1:0] stage_q,
  input logic [N-1:0] pair_hit,
  input logic         ds_q,
  input logic         fwd_q
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (scan_out == '0 && stage_q == '0 && !ds_q));

  assert_fwd_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dir_fwd |=> (stage_q == {$past(stage_q[N-2:0]), $past(pulse_a_in)}));

  assert_rev_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_fwd |=> (stage_q == {$past(pulse_b_in), $past(stage_q[N-1:1])}));

  assert_cascade_fwd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_q |-> (pulse_b_oe && !pulse_a_oe && pulse_b_out == stage_q[N-1] && !pulse_a_out));

  assert_cascade_rev_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_q |-> (pulse_a_oe && !pulse_b_oe && pulse_a_out == stage_q[0] && !pulse_b_out));

  assert_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (scan_out == '0));

  assert_no_extra_rows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_q && $countones(stage_q) == 1) |-> ($countones(scan_out) <= 2));

  assert_trim_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_q && !dbl_width) |-> ((scan_out & ~pair_hit) == '0));

  assert_normal_rows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ds_q && oe) |-> (scan_out == stage_q));

endmodule

bind gate_scan_shifter gsc_checker #(.N(NUM_STAGES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dir_fwd     (dir_fwd),
  .oe          (oe),
  .dbl_width   (dbl_width),
  .pulse_a_in  (pulse_a_in),
  .pulse_b_in  (pulse_b_in),
  .pulse_a_out (pulse_a_out),
  .pulse_b_out (pulse_b_out),
  .pulse_a_oe  (pulse_a_oe),
  .pulse_b_oe  (pulse_b_oe),
  .scan_out    (scan_out),
  .stage_q     (stage_q),
  .pair_hit    (pair_hit),
  .ds_q        (ds_q),
  .fwd_q       (fwd_q)
);

// File: tb/gate_scan_shifter_tb.sv
module gate_scan_shifter_tb;

  localparam int N = 240;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         dir_fwd = 1'b1;
  logic         oe = 1'b1;
  logic         dbl_scan = 1'b0;
  logic         dbl_width = 1'b1;
  logic         pulse_a_in = 1'b0;
  logic         pulse_b_in = 1'b0;
  logic         pulse_a_out, pulse_a_oe, pulse_b_out, pulse_b_oe;
  logic [N-1:0] scan_out;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  // Reference state: token positions, registered mode bits.
  int pos[$];
  bit m_ds = 0;
  bit m_fwd = 1;
  string tag = "R1";

  always #2.5 clk = ~clk;

  gate_scan_shifter #(.NUM_STAGES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .dir_fwd(dir_fwd), .oe(oe),
    .dbl_scan(dbl_scan), .dbl_width(dbl_width),
    .pulse_a_in(pulse_a_in), .pulse_a_out(pulse_a_out), .pulse_a_oe(pulse_a_oe),
    .pulse_b_in(pulse_b_in), .pulse_b_out(pulse_b_out), .pulse_b_oe(pulse_b_oe),
    .scan_out(scan_out)
  );

  function automatic bit occupied(int p);
    foreach (pos[k]) if (pos[k] == p) return 1;
    return 0;
  endfunction

  task automatic model_edge();
    int nxt[$];
    if (!rst_n) begin
      pos.delete();
      m_ds = 0;
      m_fwd = 1;
      return;
    end
    foreach (pos[k]) begin
      int np = dir_fwd ? pos[k] + 1 : pos[k] - 1;
      if (np >= 0 && np < N) nxt.push_back(np);
    end
    if (dir_fwd && pulse_a_in) nxt.push_back(0);
    if (!dir_fwd && pulse_b_in) nxt.push_back(N - 1);
    pos = nxt;
    m_ds = dbl_scan;
    m_fwd = dir_fwd;
  endtask

  task automatic compare(string t);
    logic [N-1:0] exp;
    bit eb_out, ea_out;
    for (int i = 0; i < N; i++) begin
      bit own = occupied(i) && (!m_ds || dbl_width);
      bit prt = m_ds && (m_fwd ? (i > 0 && occupied(i - 1)) : (i < N - 1 && occupied(i + 1)));
      exp[i] = oe && (own || prt);
    end
    total++;
    if (scan_out !== exp) begin
      bad++;
      $display("FAIL %s scan_out actual=%h expected=%h", t, scan_out, exp);
    end
    eb_out = m_fwd && occupied(N - 1);
    ea_out = !m_fwd && occupied(0);
    total++;
    if ({pulse_a_oe, pulse_b_oe, pulse_a_out, pulse_b_out} !== {!m_fwd, m_fwd, ea_out, eb_out}) begin
      bad++;
      $display("FAIL %s cascade actual=%b expected=%b", t,
               {pulse_a_oe, pulse_b_oe, pulse_a_out, pulse_b_out}, {!m_fwd, m_fwd, ea_out, eb_out});
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cycles++;
    compare(tag);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic inject_a();
    pulse_a_in = 1'b1;
    tick();
    pulse_a_in = 1'b0;
  endtask

  task automatic inject_b();
    pulse_b_in = 1'b1;
    tick();
    pulse_b_in = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    // R1: reset state
    tag = "R1";
    run(3);
    rst_n = 1'b1;

    // R2 and R4: forward travel and cascade exit at the last stage
    tag = "R2/R4 forward";
    dir_fwd = 1'b1;
    inject_a();
    run(10);
    // R10: exit-end input ignored while forward
    tag = "R10 ignored b_in";
    inject_b();
    tag = "R2/R4 forward";
    run(240);

    // R3 and R4: reverse travel and exit at stage 0
    tag = "R3/R4 reverse";
    dir_fwd = 1'b0;
    tick();
    inject_b();
    run(5);
    // R10: exit-end input ignored while reverse
    tag = "R10 ignored a_in";
    inject_a();
    tag = "R3/R4 reverse";
    run(240);

    // R5: blanking keeps the register running
    tag = "R5 blank";
    dir_fwd = 1'b1;
    inject_a();
    run(20);
    oe = 1'b0;
    run(30);
    oe = 1'b1;
    run(20);
    run(200);

    // R8: two tokens travel together
    tag = "R8 two tokens";
    inject_a();
    run(4);
    inject_a();
    run(250);

    // R9: mid-chain reversal
    tag = "R9 reversal";
    inject_a();
    run(50);
    dir_fwd = 1'b0;
    run(30);
    dir_fwd = 1'b1;
    run(20);
    dir_fwd = 1'b0;
    run(80);

    // R6 and R7: double scan forward with trim
    tag = "R6 double fwd";
    dir_fwd = 1'b1;
    dbl_scan = 1'b1;
    tick();
    inject_a();
    run(10);
    tag = "R7 trim";
    dbl_width = 1'b0;
    #1;
    compare("R7 async drop");
    run(3);
    dbl_width = 1'b1;
    #1;
    compare("R7 async restore");
    tag = "R6 double fwd end";
    run(240);
    // R6: double scan reverse, partner at k-1, none past stage 0
    tag = "R6 double rev";
    dir_fwd = 1'b0;
    tick();
    inject_b();
    run(242);
    // R7: trim ignored in normal mode
    tag = "R7 normal mode";
    dbl_scan = 1'b0;
    tick();
    inject_b();
    run(5);
    dbl_width = 1'b0;
    #1;
    compare("R7 no effect normal");
    run(5);
    dbl_width = 1'b1;

    // R1: reset mid-run clears tokens and mode
    tag = "R1 mid reset";
    dbl_scan = 1'b1;
    dir_fwd = 1'b1;
    inject_a();
    run(8);
    rst_n = 1'b0;
    run(2);
    rst_n = 1'b1;
    dbl_scan = 1'b0;
    run(5);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule